// File: doc/BRIEF.md
# UART Interrupt and Status Register Bank

This block is the software-visible register bank of a UART. It sits on a 32-bit, word-addressed bus. Through that bus it offers an interrupt state register, an interrupt enable register, an interrupt test register, a control register, a status register and a one-byte receive holding register. It also drives four level interrupt lines. The serial shifters and the transmit FIFO are outside the block. The receive side hands over each byte as a one-cycle valid pulse. The transmit FIFO reports its changes as one-cycle event pulses. The bank turns both into status bits and interrupt state.

Two small state machines hold the status. The receive holder has two states. `RXH_EMPTY` is the reset state. A byte accepted while receive is enabled moves it to `RXH_HELD` ("accept"). A read of the receive-data register while receive is enabled moves it back to `RXH_EMPTY` ("take"). If accept and take fall in the same cycle, accept wins. The transmit tracker has three states: `TXS_EMPTY` (reset), `TXS_BUSY` and `TXS_FULL`. It follows these transitions:
- "load" moves `TXS_EMPTY` to `TXS_BUSY`.
- "full" moves `TXS_EMPTY` or `TXS_BUSY` to `TXS_FULL`.
- "pop" moves `TXS_FULL` to `TXS_BUSY`.
- "drain" moves `TXS_BUSY` or `TXS_FULL` to `TXS_EMPTY`.

Within one cycle, drain takes precedence over full, full over load, and load over pop.

Word offsets: 0 interrupt state, 1 interrupt enable, 2 interrupt test, 3 control, 4 status, 5 receive data, 6 transmit data. Interrupt bits: 0 tx watermark, 1 rx watermark, 2 tx empty, 3 rx overflow.

Top module: `uart_csr_bank`

## Requirements
- R1: After reset the status register reads 0x3C. Every other register reads 0. All four interrupt lines and both enable outputs are low.
- R2: Interrupt line i is high exactly when state bit i and enable bit i are both 1.
- R3: A write to offset 0 clears each state bit whose write-data bit is 1 and leaves the other state bits unchanged.
- R4: A write to offset 2 ORs write-data bits 3:0 into the state register. A read of offset 2 returns 0.
- R5: A hardware set event wins over a same-cycle software clear of the same state bit.
- R6: When control bit 1 (rx enable) is 1, a received byte is stored and the holder enters `RXH_HELD`. Status then shows rxfull (bit 1) = 1, rxidle (bit 4) = 0 and rxempty (bit 5) = 0, and state bit 1 is set.
- R7: A received byte that arrives while rx enable is 0 changes no register.
- R8: A read of offset 5 returns the held byte. If rx is enabled, the read returns status bits 5:4 to 1 and bit 1 to 0. If rx is disabled, the read leaves the status unchanged. The held byte stays readable after the read.
- R9: A byte accepted while a byte is already held sets state bit 3 (rx overflow) and replaces the held byte.
- R10: Status bit 0 (txfull) is 1 only in `TXS_FULL`. Status bits 2 (txempty) and 3 (txidle) are 1 only in `TXS_EMPTY`. The tracker follows the transitions listed above.
- R11: A transmit drain event sets state bit 2. A transmit watermark event sets state bit 0.
- R12: Writes to offsets 4, 5 and 6, and to unmapped offsets 7 to 15, change nothing. Reads of offset 6 and of offsets 7 to 15 return 0.
- R13: The control register holds all 32 written bits and reads them back. Control bit 0 drives `tx_en` and control bit 1 drives `rx_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 4 | Word offset |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe (side effects at the clock edge) |
| bus_rdata | output | 32 | Read data, combinational while `bus_re` is high |
| rx_valid | input | 1 | Received-byte pulse |
| rx_byte | input | 8 | Received byte |
| tx_wmark_evt | input | 1 | Transmit FIFO reached its watermark |
| tx_load_evt | input | 1 | Transmit FIFO took a byte |
| tx_full_evt | input | 1 | Transmit FIFO became full |
| tx_pop_evt | input | 1 | Transmit FIFO sent a byte and is not yet empty |
| tx_empty_evt | input | 1 | Transmit FIFO became empty |
| irq_tx_wmark | output | 1 | Interrupt, tx watermark |
| irq_rx_wmark | output | 1 | Interrupt, rx watermark |
| irq_tx_empty | output | 1 | Interrupt, tx empty |
| irq_rx_ovf | output | 1 | Interrupt, rx overflow |
| tx_en | output | 1 | Control bit 0 |
| rx_en | output | 1 | Control bit 1 |

## Verification
The bench sweeps all 256 pairs of state and enable values. Any gating of an interrupt line by the wrong bit therefore shows up as a wrong line for some pair. It also sweeps every clear mask, so a clear that acts on all bits or inverts the mask leaves a wrong state value. It drives a clear in the same cycle as hardware set events; a design that lets software win would read those bits back as 0. It checks the receive handshake with rx enabled and disabled, and with back-to-back bytes. A read that empties the holder regardless of rx enable, or a missing overflow flag, shows up in the status and state values.

// File: rtl/ucsr_pkg.sv
package ucsr_pkg;
    localparam int unsigned NUM_IRQ = 4;
    localparam int unsigned IRQ_TXWM  = 0;
    localparam int unsigned IRQ_RXWM  = 1;
    localparam int unsigned IRQ_TXEMP = 2;
    localparam int unsigned IRQ_RXOVF = 3;

    localparam int unsigned OFS_ISTATE  = 0;
    localparam int unsigned OFS_IENABLE = 1;
    localparam int unsigned OFS_ITEST   = 2;
    localparam int unsigned OFS_CTRL    = 3;
    localparam int unsigned OFS_STATUS  = 4;
    localparam int unsigned OFS_RDATA   = 5;
    localparam int unsigned OFS_WDATA   = 6;

    localparam int unsigned CTRL_TXEN_BIT = 0;
    localparam int unsigned CTRL_RXEN_BIT = 1;

    typedef enum logic {
        RXH_EMPTY = 1'b0,
        RXH_HELD  = 1'b1
    } rxh_state_e;

    typedef enum logic [1:0] {
        TXS_EMPTY = 2'd0,
        TXS_BUSY  = 2'd1,
        TXS_FULL  = 2'd2
    } txs_state_e;

    // Field order gives bit 0 = txfull ... bit 5 = rxempty.
    typedef struct packed {
        logic rxempty;
        logic rxidle;
        logic txidle;
        logic txempty;
        logic rxfull;
        logic txfull;
    } status_t;
endpackage

// File: rtl/ucsr_irq.sv
module ucsr_irq #(
    parameter int unsigned N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_we,
    input  logic         tst_we,
    input  logic         en_we,
    input  logic [N-1:0] wmask,
    input  logic [N-1:0] hw_set,
    output logic [N-1:0] state_o,
    output logic [N-1:0] enable_o,
    output logic [N-1:0] irq_o
);
    logic [N-1:0] state_q, state_d;
    logic [N-1:0] enable_q;

    // Software clear first, then test and hardware sets OR on top (hardware wins).
    always_comb begin
        state_d = state_q;
        if (clr_we) state_d = state_d & ~wmask;
        if (tst_we) state_d = state_d | wmask;
        state_d = state_d | hw_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= '0;
            enable_q <= '0;
        end else begin
            state_q <= state_d;
            if (en_we) enable_q <= wmask;
        end
    end

    generate
        for (genvar i = 0; i < N; i++) begin : g_line
            assign irq_o[i] = state_q[i] & enable_q[i];
        end
    endgenerate

    assign state_o  = state_q;
    assign enable_o = enable_q;

    assert_gate_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_q == '0) |-> (irq_o == '0));
    assert_w1c_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && !tst_we && hw_set == '0) |=> ((state_q & $past(wmask)) == '0));
    assert_test_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tst_we |=> ((state_q & $past(wmask)) == $past(wmask)));
    assert_hw_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_set != '0) |=> ((state_q & $past(hw_set)) == $past(hw_set)));
endmodule

// File: rtl/ucsr_rxhold.sv
module ucsr_rxhold
    import ucsr_pkg::*;
#(
    parameter int unsigned BW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_en,
    input  logic          rx_valid,
    input  logic [BW-1:0] rx_byte,
    input  logic          rd_take,
    output logic [BW-1:0] held_byte,
    output logic          st_rxfull,
    output logic          st_rxidle,
    output logic          st_rxempty,
    output logic          set_wmark,
    output logic          set_ovf
);
    rxh_state_e    st_q, st_d;
    logic [BW-1:0] byte_q;
    logic          accept, take;

    assign accept = rx_valid & rx_en;
    assign take   = rd_take & rx_en;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            RXH_EMPTY: if (accept) st_d = RXH_HELD;
            RXH_HELD:  if (!accept && take) st_d = RXH_EMPTY;
            default:   st_d = RXH_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= RXH_EMPTY;
            byte_q <= '0;
        end else begin
            st_q <= st_d;
            if (accept) byte_q <= rx_byte;
        end
    end

    always_comb begin
        held_byte  = byte_q;
        st_rxfull  = (st_q == RXH_HELD);
        st_rxidle  = (st_q == RXH_EMPTY);
        st_rxempty = (st_q == RXH_EMPTY);
        set_wmark  = accept;
        set_ovf    = accept && (st_q == RXH_HELD) && !take;
    end

    assert_accept_fills_R6: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (st_q == RXH_HELD && byte_q == $past(rx_byte)));
    assert_disabled_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> (byte_q == $past(byte_q)));
    assert_take_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !accept) |=> (st_q == RXH_EMPTY));
endmodule

// File: rtl/ucsr_txstat.sv
module ucsr_txstat
    import ucsr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ev_load,
    input  logic ev_full,
    input  logic ev_pop,
    input  logic ev_drain,
    output logic st_txfull,
    output logic st_txempty,
    output logic st_txidle
);
    txs_state_e st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            TXS_EMPTY: begin
                if (ev_drain)     st_d = TXS_EMPTY;
                else if (ev_full) st_d = TXS_FULL;
                else if (ev_load) st_d = TXS_BUSY;
            end
            TXS_BUSY: begin
                if (ev_drain)     st_d = TXS_EMPTY;
                else if (ev_full) st_d = TXS_FULL;
            end
            TXS_FULL: begin
                if (ev_drain)     st_d = TXS_EMPTY;
                else if (ev_pop)  st_d = TXS_BUSY;
            end
            default: st_d = TXS_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= TXS_EMPTY;
        else        st_q <= st_d;
    end

    always_comb begin
        st_txfull  = (st_q == TXS_FULL);
        st_txempty = (st_q == TXS_EMPTY);
        st_txidle  = (st_q == TXS_EMPTY);
    end

    assert_drain_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ev_drain |=> (st_txempty && !st_txfull));
    assert_full_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_txfull && st_txempty));
endmodule

// File: rtl/uart_csr_bank.sv
module uart_csr_bank
    import ucsr_pkg::*;
#(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    input  logic              bus_re,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              tx_wmark_evt,
    input  logic              tx_load_evt,
    input  logic              tx_full_evt,
    input  logic              tx_pop_evt,
    input  logic              tx_empty_evt,
    output logic              irq_tx_wmark,
    output logic              irq_rx_wmark,
    output logic              irq_tx_empty,
    output logic              irq_rx_ovf,
    output logic              tx_en,
    output logic              rx_en
);
    localparam int unsigned STATUS_W = $bits(status_t);

    logic [DATA_W-1:0]  ctrl_q;
    logic [NUM_IRQ-1:0] istate, ienable, irq_vec, hw_set;
    logic               hit_istate, hit_ienable, hit_itest, hit_ctrl, hit_rdata;
    logic               rx_set_wm, rx_set_ovf;
    logic [BYTE_W-1:0]  held_byte;
    status_t            status;

    assign hit_istate  = (bus_addr == ADDR_W'(OFS_ISTATE));
    assign hit_ienable = (bus_addr == ADDR_W'(OFS_IENABLE));
    assign hit_itest   = (bus_addr == ADDR_W'(OFS_ITEST));
    assign hit_ctrl    = (bus_addr == ADDR_W'(OFS_CTRL));
    assign hit_rdata   = (bus_addr == ADDR_W'(OFS_RDATA));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   ctrl_q <= '0;
        else if (bus_we && hit_ctrl)  ctrl_q <= bus_wdata;
    end

    assign tx_en = ctrl_q[CTRL_TXEN_BIT];
    assign rx_en = ctrl_q[CTRL_RXEN_BIT];

    always_comb begin
        hw_set            = '0;
        hw_set[IRQ_TXWM]  = tx_wmark_evt;
        hw_set[IRQ_RXWM]  = rx_set_wm;
        hw_set[IRQ_TXEMP] = tx_empty_evt;
        hw_set[IRQ_RXOVF] = rx_set_ovf;
    end

    ucsr_irq #(.N(NUM_IRQ)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_we   (bus_we && hit_istate),
        .tst_we   (bus_we && hit_itest),
        .en_we    (bus_we && hit_ienable),
        .wmask    (bus_wdata[NUM_IRQ-1:0]),
        .hw_set   (hw_set),
        .state_o  (istate),
        .enable_o (ienable),
        .irq_o    (irq_vec)
    );

    ucsr_rxhold #(.BW(BYTE_W)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_en      (rx_en),
        .rx_valid   (rx_valid),
        .rx_byte    (rx_byte),
        .rd_take    (bus_re && hit_rdata),
        .held_byte  (held_byte),
        .st_rxfull  (status.rxfull),
        .st_rxidle  (status.rxidle),
        .st_rxempty (status.rxempty),
        .set_wmark  (rx_set_wm),
        .set_ovf    (rx_set_ovf)
    );

    ucsr_txstat u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .ev_load    (tx_load_evt),
        .ev_full    (tx_full_evt),
        .ev_pop     (tx_pop_evt),
        .ev_drain   (tx_empty_evt),
        .st_txfull  (status.txfull),
        .st_txempty (status.txempty),
        .st_txidle  (status.txidle)
    );

    assign irq_tx_wmark = irq_vec[IRQ_TXWM];
    assign irq_rx_wmark = irq_vec[IRQ_RXWM];
    assign irq_tx_empty = irq_vec[IRQ_TXEMP];
    assign irq_rx_ovf   = irq_vec[IRQ_RXOVF];

    always_comb begin
        bus_rdata = '0;
        if (bus_re) begin
            case (bus_addr)
                ADDR_W'(OFS_ISTATE):  bus_rdata = DATA_W'(istate);
                ADDR_W'(OFS_IENABLE): bus_rdata = DATA_W'(ienable);
                ADDR_W'(OFS_CTRL):    bus_rdata = ctrl_q;
                ADDR_W'(OFS_STATUS):  bus_rdata = DATA_W'(status);
                ADDR_W'(OFS_RDATA):   bus_rdata = DATA_W'(held_byte);
                default:              bus_rdata = '0;
            endcase
        end
    end

    assert_unmapped_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && bus_addr > ADDR_W'(OFS_WDATA)) |-> (bus_rdata == '0));
    assert_ctrl_rxen_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && hit_ctrl) |=> (rx_en == $past(bus_wdata[CTRL_RXEN_BIT])));
    assert_ovf_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_set_ovf |=> istate[IRQ_RXOVF]);
    assert_status_width_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && bus_addr == ADDR_W'(OFS_STATUS)) |-> (bus_rdata[DATA_W-1:STATUS_W] == '0));
endmodule

// File: tb/uart_csr_bank_test.sv
module uart_csr_bank_test;
    logic        clk = 0;
    logic        rst_n = 0;
    logic [3:0]  bus_addr = 0;
    logic [31:0] bus_wdata = 0;
    logic        bus_we = 0, bus_re = 0;
    logic [31:0] bus_rdata;
    logic        rx_valid = 0;
    logic [7:0]  rx_byte = 0;
    logic        tx_wmark_evt = 0, tx_load_evt = 0, tx_full_evt = 0, tx_pop_evt = 0, tx_empty_evt = 0;
    logic        irq_tx_wmark, irq_rx_wmark, irq_tx_empty, irq_rx_ovf, tx_en, rx_en;
    int          checks = 0, failures = 0;
    logic [31:0] v;

    always #5 clk = ~clk;

    uart_csr_bank uut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1;
        @(negedge clk); bus_we = 0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk); bus_addr = a; bus_re = 1; #1 d = bus_rdata;
        @(negedge clk); bus_re = 0;
    endtask

    // m: {drain, pop, full, load, wmark}
    task automatic txev(input logic [4:0] m);
        @(negedge clk);
        {tx_empty_evt, tx_pop_evt, tx_full_evt, tx_load_evt, tx_wmark_evt} = m;
        @(negedge clk);
        {tx_empty_evt, tx_pop_evt, tx_full_evt, tx_load_evt, tx_wmark_evt} = '0;
    endtask

    task automatic rxb(input logic [7:0] b);
        @(negedge clk); rx_byte = b; rx_valid = 1;
        @(negedge clk); rx_valid = 0;
    endtask

    function automatic logic [31:0] irqs();
        return {28'd0, irq_rx_ovf, irq_tx_empty, irq_rx_wmark, irq_tx_wmark};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset values
        rd(0, v); chk("R1 istate", v, 0);
        rd(1, v); chk("R1 ienable", v, 0);
        rd(3, v); chk("R1 ctrl", v, 0);
        rd(4, v); chk("R1 status", v, 32'h3C);
        rd(5, v); chk("R1 rdata", v, 0);
        chk("R1 irq", irqs(), 0);
        chk("R1 enables", {30'd0, rx_en, tx_en}, 0);

        // R13 control
        wr(3, 32'hABCD_0003);
        rd(3, v); chk("R13 ctrl readback", v, 32'hABCD_0003);
        chk("R13 en both", {30'd0, rx_en, tx_en}, 3);
        wr(3, 32'h2);
        chk("R13 rx only", {30'd0, rx_en, tx_en}, 2);

        // R2/R4 sweep over state and enable
        for (int s = 0; s < 16; s++) begin
            for (int e = 0; e < 16; e++) begin
                wr(0, 32'hF);
                wr(2, s);
                wr(1, e);
                chk("R2 irq gating", irqs(), s & e);
            end
            rd(0, v); chk("R4 test sets state", v, s);
        end
        rd(2, v); chk("R4 test reads zero", v, 0);

        // R3 clear mask sweep
        for (int m = 0; m < 16; m++) begin
            wr(2, 32'hF);
            wr(0, m);
            rd(0, v); chk("R3 w1c", v, 32'hF & ~m);
        end

        // R5 hardware set beats same-cycle clear
        wr(2, 32'hF);
        @(negedge clk);
        bus_addr = 0; bus_wdata = 32'hF; bus_we = 1; tx_wmark_evt = 1; tx_empty_evt = 1;
        @(negedge clk);
        bus_we = 0; tx_wmark_evt = 0; tx_empty_evt = 0;
        rd(0, v); chk("R5 hw wins", v, 32'h5);

        // R7 byte ignored while rx disabled
        wr(3, 0); wr(0, 32'hF);
        rxb(8'h55);
        rd(4, v); chk("R7 status", v, 32'h3C);
        rd(5, v); chk("R7 rdata", v, 0);
        rd(0, v); chk("R7 istate", v, 0);

        // R6 accept, R8 read handshake
        wr(3, 2);
        rxb(8'hA5);
        rd(4, v); chk("R6 status held", v, 32'h0E);
        rd(0, v); chk("R6 rx wmark", v, 32'h2);
        rd(5, v); chk("R6 byte", v, 32'hA5);
        rd(4, v); chk("R8 status after read", v, 32'h3C);
        rd(5, v); chk("R8 byte kept", v, 32'hA5);

        // R9 overflow
        wr(0, 32'hF);
        rxb(8'h11);
        rxb(8'h22);
        rd(0, v); chk("R9 overflow state", v, 32'hA);
        // R8 read while disabled leaves status
        wr(3, 0);
        rd(5, v); chk("R9 overwrite", v, 32'h22);
        rd(4, v); chk("R8 disabled read", v, 32'h0E);
        wr(3, 2);
        rd(5, v);
        rd(4, v); chk("R8 enabled read", v, 32'h3C);

        // R10/R11 transmit tracker
        wr(0, 32'hF);
        txev(5'b00010); rd(4, v); chk("R10 load", v, 32'h30);
        txev(5'b00100); rd(4, v); chk("R10 full", v, 32'h31);
        txev(5'b01000); rd(4, v); chk("R10 pop", v, 32'h30);
        txev(5'b10000); rd(4, v); chk("R10 drain", v, 32'h3C);
        rd(0, v); chk("R11 drain sets bit2", v, 32'h4);
        txev(5'b00001); rd(0, v); chk("R11 wmark sets bit0", v, 32'h5);

        // R12 ignored writes and zero reads
        wr(1, 32'h9);
        wr(4, 32'hFFFF_FFFF); rd(4, v); chk("R12 status write", v, 32'h3C);
        wr(5, 32'h99);        rd(5, v); chk("R12 rdata write", v, 32'h22);
        wr(6, 32'h77);        rd(6, v); chk("R12 wdata read", v, 0);
        for (int a = 7; a < 16; a++) begin
            wr(a[3:0], 32'hFFFF_FFFF);
            rd(a[3:0], v); chk("R12 unmapped read", v, 0);
        end
        rd(3, v); chk("R12 ctrl kept", v, 32'h2);
        rd(1, v); chk("R12 enable kept", v, 32'h9);
        rd(0, v); chk("R12 state kept", v, 32'h5);
        chk("R12 irq kept", irqs(), 32'h1);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule